// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects interrupt sources that belong to individual processor cores and turns them into one pending word and one interrupt request line per core. Each core sees ten sources: four timer lines, four 32-bit inter-processor mailboxes, one peripheral interrupt that is steered to a single chosen core, and its own performance-monitor line. Each source passes through an enable, and a core's request line is raised whenever any enabled source of that core is active.

Software reaches the block through a simple single-cycle register port. A core posts a message to another core by OR-ing bits into one of the target's mailboxes through a set address. The receiver reads the mailbox through its clear address and acknowledges by writing the read value back, which clears exactly those bits. The performance-monitor routing is changed through a pair of set and clear registers so that one core's setting never disturbs another's. A control word and a prescaler word are kept as plain read/write storage for start-up code.

Top module: `lir_router`

## Requirements
- R1: After reset every register reads 0 (control, prescaler, timer enables, mailbox enables, performance-monitor routing, peripheral selector and all mailboxes), every pending bit is 0 and every core_irq is low.
- R2: The control word (word address 0) and the prescaler word (word address 1) store all 32 written bits and read them back unchanged.
- R3: For core c, the timer enable register at word address 8+c holds 4 bits (wider write bits are dropped); pending bit t (t = 0..3) of core c equals timer_irq[4c+t] AND enable bit t.
- R4: Writing value v to the mailbox-set address of core c, mailbox m (word address 32+4c+m) ORs v into that mailbox; reading a set address returns 0.
- R5: Reading the mailbox-clear address of core c, mailbox m (word address 48+4c+m) returns the mailbox contents; writing v there clears exactly the bits that are 1 in v and leaves the rest.
- R6: For core c, the mailbox enable register at word address 12+c holds 4 bits; pending bit 4+m is 1 exactly when mailbox m is nonzero and enable bit m is 1, so writing 1 enables mailbox 0 only.
- R7: The peripheral selector at word address 4 holds 2 bits (reset value 0, core 0); pending bit 8 is set for the selected core only, and only while periph_irq is high.
- R8: Writing to word address 2 ORs the low NUM_CORES data bits into the routing mask and writing to word address 3 clears the mask bits written as 1; both addresses read the mask; pending bit 9 of core c equals pmu_irq[c] AND mask bit c.
- R9: core_irq[c] is high exactly when any of the ten pending bits of core c is 1; the pending word of core c also reads at word address 16+c.
- R10: Addresses outside the map (5 to 7, 20 to 31, and per-core addresses of cores beyond NUM_CORES) read 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe, data taken at the rising edge |
| reg_addr | input | 6 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| timer_irq | input | NUM_CORES*4 | Timer lines, four per core, core c at bits 4c..4c+3 |
| periph_irq | input | 1 | Peripheral interrupt to be steered to one core |
| pmu_irq | input | NUM_CORES | Performance-monitor line per core |
| pend_word | output | NUM_CORES*10 | Pending word per core, core c at bits 10c..10c+9 |
| core_irq | output | NUM_CORES | Interrupt request per core |

## Verification
On every cycle the assertions check that timer pending bits never appear without their input, that the peripheral bit lands on at most one core and only while its input is high, that each core's request line tracks its pending word, and that every mailbox keeps, gains or loses bits only as the last write to its own set or clear address dictates. What those properties cannot show is that the enables, the selector and the routing mask decode the right fields from the right addresses, that the clear address reads back what was posted, and that unmapped writes leave everything intact; those come from the bench's register table and its directed scenarios.

// File: rtl/lir_pkg.sv
package lir_pkg;

  localparam int SRC_PER_CORE = 10;
  localparam int TMR_N        = 4;
  localparam int MBX_N        = 4;
  localparam int REG_AW       = 6;
  localparam int DATA_W       = 32;
  localparam int CORE_SLOTS   = 4;
  localparam int CORE_IW      = $clog2(CORE_SLOTS);
  localparam int SLOT_IW      = $clog2(MBX_N);

  // word addresses of the register map
  localparam logic [REG_AW-1:0] A_CTRL      = 6'd0;
  localparam logic [REG_AW-1:0] A_PRESC     = 6'd1;
  localparam logic [REG_AW-1:0] A_PMU_SET   = 6'd2;
  localparam logic [REG_AW-1:0] A_PMU_CLR   = 6'd3;
  localparam logic [REG_AW-1:0] A_PSEL      = 6'd4;
  localparam logic [REG_AW-1:0] A_TMR_BASE  = 6'd8;
  localparam logic [REG_AW-1:0] A_MEN_BASE  = 6'd12;
  localparam logic [REG_AW-1:0] A_PEND_BASE = 6'd16;
  localparam logic [REG_AW-1:0] A_MSET_BASE = 6'd32;
  localparam logic [REG_AW-1:0] A_MCLR_BASE = 6'd48;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_PRESC, K_PMU_SET, K_PMU_CLR, K_PSEL,
    K_TMR, K_MEN, K_PEND, K_MSET, K_MCLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [CORE_IW-1:0] core;
    logic [SLOT_IW-1:0] slot;
  } reg_dec_t;

  // next mailbox value: set bits OR in, clear bits knock out (clear last)
  function automatic logic [DATA_W-1:0] mbox_next(
    input logic [DATA_W-1:0] cur,
    input logic              do_set,
    input logic              do_clr,
    input logic [DATA_W-1:0] val
  );
    logic [DATA_W-1:0] tmp;
    tmp = cur;
    if (do_set) tmp = tmp | val;
    if (do_clr) tmp = tmp & ~val;
    return tmp;
  endfunction

  // pending word: {pmu, periph, mailboxes[3:0], timers[3:0]}
  function automatic logic [SRC_PER_CORE-1:0] pend_combine(
    input logic [TMR_N-1:0] tmr,
    input logic [TMR_N-1:0] tmr_en,
    input logic [MBX_N-1:0] mbx_nz,
    input logic [MBX_N-1:0] mbx_en,
    input logic             periph,
    input logic             pmu
  );
    return {pmu, periph, mbx_nz & mbx_en, tmr & tmr_en};
  endfunction

endpackage

// File: rtl/lir_decode.sv
module lir_decode
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [REG_AW-1:0] addr,
  output reg_dec_t          dec
);

  logic per_core;

  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    per_core = 1'b0;
    if (addr == A_CTRL) begin
      dec.kind = K_CTRL;
    end else if (addr == A_PRESC) begin
      dec.kind = K_PRESC;
    end else if (addr == A_PMU_SET) begin
      dec.kind = K_PMU_SET;
    end else if (addr == A_PMU_CLR) begin
      dec.kind = K_PMU_CLR;
    end else if (addr == A_PSEL) begin
      dec.kind = K_PSEL;
    end else if (addr[5:2] == A_TMR_BASE[5:2]) begin
      dec.kind = K_TMR;
      dec.core = addr[1:0];
      per_core = 1'b1;
    end else if (addr[5:2] == A_MEN_BASE[5:2]) begin
      dec.kind = K_MEN;
      dec.core = addr[1:0];
      per_core = 1'b1;
    end else if (addr[5:2] == A_PEND_BASE[5:2]) begin
      dec.kind = K_PEND;
      dec.core = addr[1:0];
      per_core = 1'b1;
    end else if (addr[5:4] == A_MSET_BASE[5:4]) begin
      dec.kind = K_MSET;
      dec.core = addr[3:2];
      dec.slot = addr[1:0];
      per_core = 1'b1;
    end else if (addr[5:4] == A_MCLR_BASE[5:4]) begin
      dec.kind = K_MCLR;
      dec.core = addr[3:2];
      dec.slot = addr[1:0];
      per_core = 1'b1;
    end
    if (per_core && (int'(dec.core) >= NUM_CORES)) begin
      dec = '0;
      dec.kind = K_NONE;
    end
  end

endmodule

// File: rtl/lir_global_regs.sv
module lir_global_regs
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  reg_dec_t             dec,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    ctrl_q,
  output logic [DATA_W-1:0]    presc_q,
  output logic [NUM_CORES-1:0] route_q,
  output logic [CORE_IW-1:0]   psel_q
);

  logic [NUM_CORES-1:0] route_bits;
  assign route_bits = wdata[NUM_CORES-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      route_q <= '0;
      psel_q  <= '0;
    end else if (we) begin
      case (dec.kind)
        K_CTRL:    ctrl_q  <= wdata;
        K_PRESC:   presc_q <= wdata;
        K_PMU_SET: route_q <= route_q | route_bits;
        K_PMU_CLR: route_q <= route_q & ~route_bits;
        K_PSEL:    psel_q  <= wdata[CORE_IW-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/lir_core_slice.sv
module lir_core_slice
  import lir_pkg::*;
#(
  parameter int CORE_ID = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  reg_dec_t                dec,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [TMR_N-1:0]        tmr_irq,
  input  logic                    periph_hit,
  input  logic                    pmu_hit,
  output logic [TMR_N-1:0]        tmr_en_q,
  output logic [MBX_N-1:0]        mbx_en_q,
  output logic [MBX_N*DATA_W-1:0] mbox_flat,
  output logic [SRC_PER_CORE-1:0] pend
);

  localparam logic [CORE_IW-1:0] MY_ID = CORE_IW'(CORE_ID);

  logic             mine;
  logic [MBX_N-1:0] mbx_nz;

  assign mine = (dec.core == MY_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en_q <= '0;
      mbx_en_q <= '0;
    end else if (we && mine) begin
      if (dec.kind == K_TMR) tmr_en_q <= wdata[TMR_N-1:0];
      if (dec.kind == K_MEN) mbx_en_q <= wdata[MBX_N-1:0];
    end
  end

  for (genvar m = 0; m < MBX_N; m++) begin : g_mbox
    logic [DATA_W-1:0] box_q;
    logic              set_hit;
    logic              clr_hit;

    assign set_hit = we && mine && (dec.kind == K_MSET) && (dec.slot == SLOT_IW'(m));
    assign clr_hit = we && mine && (dec.kind == K_MCLR) && (dec.slot == SLOT_IW'(m));

    always_ff @(posedge clk) begin
      if (!rst_n) box_q <= '0;
      else        box_q <= mbox_next(box_q, set_hit, clr_hit, wdata);
    end

    assign mbx_nz[m]                     = |box_q;
    assign mbox_flat[m*DATA_W +: DATA_W] = box_q;
  end

  assign pend = pend_combine(tmr_irq, tmr_en_q, mbx_nz, mbx_en_q, periph_hit, pmu_hit);

endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [REG_AW-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  input  logic [NUM_CORES*TMR_N-1:0]        timer_irq,
  input  logic                              periph_irq,
  input  logic [NUM_CORES-1:0]              pmu_irq,
  output logic [NUM_CORES*SRC_PER_CORE-1:0] pend_word,
  output logic [NUM_CORES-1:0]              core_irq
);

  localparam int BOX_BITS = MBX_N * DATA_W;

  reg_dec_t                   dec;
  logic [DATA_W-1:0]          ctrl_q;
  logic [DATA_W-1:0]          presc_q;
  logic [NUM_CORES-1:0]       route_q;
  logic [CORE_IW-1:0]         psel_q;
  logic [TMR_N-1:0]           tmr_en_a [NUM_CORES];
  logic [MBX_N-1:0]           mbx_en_a [NUM_CORES];
  logic [BOX_BITS-1:0]        box_a    [NUM_CORES];
  logic [SRC_PER_CORE-1:0]    pend_a   [NUM_CORES];
  logic [NUM_CORES*BOX_BITS-1:0] mbox_all;  // observed by the checker

  lir_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .addr (reg_addr),
    .dec  (dec)
  );

  lir_global_regs #(.NUM_CORES(NUM_CORES)) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .dec     (dec),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .presc_q (presc_q),
    .route_q (route_q),
    .psel_q  (psel_q)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic periph_hit;
    logic pmu_hit;

    assign periph_hit = periph_irq && (psel_q == CORE_IW'(c));
    assign pmu_hit    = pmu_irq[c] && route_q[c];

    lir_core_slice #(.CORE_ID(c)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .dec        (dec),
      .wdata      (reg_wdata),
      .tmr_irq    (timer_irq[c*TMR_N +: TMR_N]),
      .periph_hit (periph_hit),
      .pmu_hit    (pmu_hit),
      .tmr_en_q   (tmr_en_a[c]),
      .mbx_en_q   (mbx_en_a[c]),
      .mbox_flat  (box_a[c]),
      .pend       (pend_a[c])
    );

    assign pend_word[c*SRC_PER_CORE +: SRC_PER_CORE] = pend_a[c];
    assign core_irq[c]                               = |pend_a[c];
    assign mbox_all[c*BOX_BITS +: BOX_BITS]          = box_a[c];
  end

  always_comb begin
    reg_rdata = '0;
    case (dec.kind)
      K_CTRL:               reg_rdata = ctrl_q;
      K_PRESC:              reg_rdata = presc_q;
      K_PMU_SET, K_PMU_CLR: reg_rdata = DATA_W'(route_q);
      K_PSEL:               reg_rdata = DATA_W'(psel_q);
      default: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (dec.core == CORE_IW'(c)) begin
            case (dec.kind)
              K_TMR:   reg_rdata = DATA_W'(tmr_en_a[c]);
              K_MEN:   reg_rdata = DATA_W'(mbx_en_a[c]);
              K_PEND:  reg_rdata = DATA_W'(pend_a[c]);
              K_MCLR:  reg_rdata = box_a[c][dec.slot*DATA_W +: DATA_W];
              default: ;
            endcase
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    reg_we,
  input logic [REG_AW-1:0]                       reg_addr,
  input logic [DATA_W-1:0]                       reg_wdata,
  input logic [NUM_CORES*TMR_N-1:0]              timer_irq,
  input logic                                    periph_irq,
  input logic [NUM_CORES*SRC_PER_CORE-1:0]       pend_word,
  input logic [NUM_CORES-1:0]                    core_irq,
  input logic [NUM_CORES*MBX_N*DATA_W-1:0]       mbox_all
);

  logic [NUM_CORES-1:0] periph_bits;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    assign periph_bits[c] = pend_word[c*SRC_PER_CORE + 8];

    AST_TIMER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_word[c*SRC_PER_CORE +: TMR_N] & ~timer_irq[c*TMR_N +: TMR_N]) == '0); // R3

    AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq[c] == (pend_word[c*SRC_PER_CORE +: SRC_PER_CORE] != '0)); // R9

    for (genvar m = 0; m < MBX_N; m++) begin : g_m
      localparam logic [REG_AW-1:0] SET_A = REG_AW'(32 + 4*c + m);
      localparam logic [REG_AW-1:0] CLR_A = REG_AW'(48 + 4*c + m);
      localparam int LO = (c*MBX_N + m) * DATA_W;

      AST_MBOX_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SET_A) |=>
          ((mbox_all[LO +: DATA_W] & $past(reg_wdata)) == $past(reg_wdata))); // R4

      AST_MBOX_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CLR_A) |=>
          ((mbox_all[LO +: DATA_W] & $past(reg_wdata)) == '0)); // R5

      AST_MBOX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == SET_A || reg_addr == CLR_A)) |=>
          $stable(mbox_all[LO +: DATA_W])); // R10
    end
  end

  AST_PERIPH_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_bits)); // R7

  AST_PERIPH_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_irq |-> (periph_bits == '0)); // R7

endmodule

bind lir_router lir_router_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .timer_irq  (timer_irq),
  .periph_irq (periph_irq),
  .pend_word  (pend_word),
  .core_irq   (core_irq),
  .mbox_all   (mbox_all)
);

// File: tb/lir_router_bench.sv
module lir_router_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC*4-1:0]  timer_irq = '0;
  logic          periph_irq = 1'b0;
  logic [NC-1:0] pmu_irq = '0;
  logic [NC*10-1:0] pend_word;
  logic [NC-1:0] core_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lir_router #(.NUM_CORES(NC)) u_lir_router (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .timer_irq (timer_irq),
    .periph_irq (periph_irq), .pmu_irq (pmu_irq), .pend_word (pend_word),
    .core_irq (core_irq)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  // write d to a, then read a and expect e
  localparam vec_t VECS [8] = '{
    '{6'd0,  32'h0000_0000, 32'h0000_0000, 4'd2},  // R2 control
    '{6'd1,  32'h8000_0000, 32'h8000_0000, 4'd2},  // R2 prescaler
    '{6'd0,  32'hA5A5_0001, 32'hA5A5_0001, 4'd2},  // R2 control full width
    '{6'd9,  32'h0000_00FF, 32'h0000_000F, 4'd3},  // R3 timer enable core 1, 4 bits
    '{6'd14, 32'h0000_0001, 32'h0000_0001, 4'd6},  // R6 mailbox enable core 2
    '{6'd4,  32'h0000_0007, 32'h0000_0003, 4'd7},  // R7 selector 2 bits
    '{6'd5,  32'hFFFF_FFFF, 32'h0000_0000, 4'd10}, // R10 unmapped
    '{6'd24, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10}  // R10 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [9:0] pw(input int c);
    return pend_word[c*10 +: 10];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd0, r);  check("R1 ctrl", r, 0);
    rd(6'd1, r);  check("R1 presc", r, 0);
    rd(6'd2, r);  check("R1 route", r, 0);
    rd(6'd4, r);  check("R1 selector", r, 0);
    rd(6'd8, r);  check("R1 timer en", r, 0);
    rd(6'd13, r); check("R1 mbox en", r, 0);
    rd(6'd49, r); check("R1 mailbox", r, 0);
    check("R1 pend", {22'd0, pend_word[9:0]}, 0);
    check("R1 irq", {28'd0, core_irq}, 0);

    // register table (R2 R3 R6 R7 R10)
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, r);
      check($sformatf("R%0d table[%0d]", VECS[i].req, i), r, VECS[i].e);
    end
    rd(6'd0, r); check("R10 ctrl after unmapped writes", r, 32'hA5A5_0001);
    rd(6'd9, r); check("R10 timer en after unmapped writes", r, 32'hF);

    // R3 timer gating, core 1 enables = 1111
    timer_irq = 16'h0050; #1;
    check("R3 timer pend all enabled", {22'd0, pw(1)}, 10'h005);
    check("R9 irq core1", {31'd0, core_irq[1]}, 1);
    check("R9 irq core0 idle", {31'd0, core_irq[0]}, 0);
    wr(6'd9, 32'h4);
    check("R3 timer pend partial", {22'd0, pw(1)}, 10'h004);
    rd(6'd17, r); check("R9 pend read core1", r, 32'h4);
    timer_irq = '0; #1;
    check("R9 irq drops", {28'd0, core_irq}, 0);

    // R4 set accumulation, core 0 mailbox 2
    wr(6'd34, 32'h11);
    wr(6'd34, 32'h22);
    rd(6'd50, r); check("R5 read mailbox", r, 32'h33);
    rd(6'd34, r); check("R4 set reads zero", r, 0);
    check("R6 disabled mailbox no pend", {22'd0, pw(0)}, 0);
    wr(6'd12, 32'h4);
    check("R6 mailbox 2 pend", {22'd0, pw(0)}, 10'h040);
    check("R9 irq by mailbox", {31'd0, core_irq[0]}, 1);

    // R6 value 1 enables mailbox 0 only (core 2)
    wr(6'd41, 32'h1);
    check("R6 mailbox 1 not enabled", {22'd0, pw(2)}, 0);
    wr(6'd40, 32'h8);
    check("R6 mailbox 0 enabled", {22'd0, pw(2)}, 10'h010);

    // R5 partial and full clear
    wr(6'd50, 32'h01);
    rd(6'd50, r); check("R5 partial clear", r, 32'h32);
    wr(6'd50, 32'h32);
    rd(6'd50, r); check("R5 full clear", r, 0);
    check("R5 pend drops", {22'd0, pw(0)}, 0);

    // R7 peripheral steering, selector = 3
    periph_irq = 1'b1; #1;
    check("R7 core3 bit8", {22'd0, pw(3)}, 10'h100);
    check("R7 core1 none", {22'd0, pw(1)}, 0);
    wr(6'd4, 32'h1);
    check("R7 moved to core1", {22'd0, pw(1)}, 10'h100);
    check("R7 core3 cleared", {22'd0, pw(3)}, 0);
    periph_irq = 1'b0; #1;
    check("R7 no source", {22'd0, pw(1)}, 0);

    // R8 performance-monitor routing
    pmu_irq = 4'hF; #1;
    check("R8 unrouted", {22'd0, pw(0)}, 0);
    wr(6'd2, 32'h5);
    check("R8 core0 routed", {22'd0, pw(0)}, 10'h200);
    check("R8 core2 routed", {22'd0, pw(2)}, 10'h210);
    check("R8 core1 not routed", {22'd0, pw(1)}, 0);
    rd(6'd3, r); check("R8 mask via clear addr", r, 32'h5);
    wr(6'd3, 32'h1);
    rd(6'd2, r); check("R8 mask after clear", r, 32'h4);
    check("R8 core0 unrouted", {22'd0, pw(0)}, 0);
    pmu_irq = '0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule